// File: doc/BRIEF.md
# Decoded-Input Programmable Logic Array

This block is a small programmable logic array in which the binary inputs are grouped two at a time. Each group of two bits is read as one four-valued variable. A small decoder turns that variable into four OR-type lines, and each line is false for exactly one of the four values. A programmable AND plane forms product columns from any chosen set of these lines. A programmable OR plane then builds each output from any chosen set of columns. One column can hold a condition on a pair, such as the equivalence of its two bits, that a plain array of true and complemented literals needs two columns to express.

The two planes are held as bit masks in on-block storage. A synchronous write port loads them: an address picks one column mask or one output mask, and the new value is stored at the next rising clock edge. With the default setting the outputs follow the inputs and the stored masks with no clock in the path. A parameter can put a register on the outputs instead.

Top module: `dec_pla`

## Requirements
- R1: Input pair p is made of bits `pla_in[2p+1]` (high, a) and `pla_in[2p]` (low, b), and its value is {a,b}. Decoder line k of pair p (k = 0..3) is false only when the pair value equals 3-k, so line 0 = a'+b', line 1 = a'+b, line 2 = a+b' and line 3 = a+b. Line k of pair p is selected in a column by mask bit 4p+k.
- R2: For any input value, exactly three of the four decoder lines of each pair are true.
- R3: A column is the AND of the lines its mask selects. A line that is not selected has no effect, so a column with an all-zero mask is 1. A column is 0 only when a selected line is false.
- R4: A column that selects lines 1 and 2 of a pair is true exactly when the two bits of that pair are equal.
- R5: Output o is the OR of the columns whose bits are set in its sum mask (bit c selects column c). An output with an all-zero sum mask is 0.
- R6: When `cfg_we` is high at a rising edge, an address c below N_COL loads column mask c from the low 4·N_IN/2 data bits, and an address N_COL+o loads sum mask o from the low N_COL data bits. The outputs change only after that edge. A write to any higher address changes no mask.
- R7: Synchronous active-low reset clears every mask, so after reset every output is 0 for all inputs.
- R8: With the default unregistered outputs, a change on `pla_in` shows on `pla_out` with no clock edge.
- R9: For any programmed masks and every input combination, `pla_out` equals the sum of products computed from R1, R3 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration storage and the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| pla_in | input | N_IN | Binary inputs, taken in pairs |
| pla_out | output | N_OUT | Array outputs |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | AW | Selects a column mask (0..N_COL-1) or a sum mask (N_COL..N_COL+N_OUT-1) |
| cfg_wdata | input | DW | Mask value to store |

## Verification
The hardest case to reach from the ports is a single decoder line acting alone, because every column combines lines and every output combines columns. The bench therefore clears all masks, programs one column with only one line bit, routes that column alone to output 0, and sweeps every input value for each of the twelve lines. Write timing is tested by holding an input that the pending write changes, and sampling the output both before and after the storing edge. Randomly programmed masks are then compared against a software sum-of-products model over all 64 input values.

// File: rtl/dpla_pkg.sv
// Shared constants and helpers for the decoded-input logic array.
// Assumes nothing beyond elaboration-time integer arithmetic.
package dpla_pkg;
    localparam int LINES_PER_PAIR = 4;

    // Larger of two elaboration-time integers.
    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/pla_pair_dec.sv
// Decodes each bit pair into four OR lines, each false for one pair value.
// Assumes: pair p uses in_bits[2p+1] as the high bit and in_bits[2p] as the low bit.
module pla_pair_dec #(
    parameter int N_PAIR = 3,
    localparam int LW = dpla_pkg::LINES_PER_PAIR * N_PAIR
) (
    input  logic [2*N_PAIR-1:0] in_bits,
    output logic [LW-1:0]       lines
);
    for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
        logic hi_b, lo_b;
        assign hi_b = in_bits[2*p+1];
        assign lo_b = in_bits[2*p];
        // Four sum lines: false at values 3, 2, 1, 0 respectively.
        always_comb begin
            lines[4*p+0] = ~hi_b | ~lo_b;
            lines[4*p+1] = ~hi_b |  lo_b;
            lines[4*p+2] =  hi_b | ~lo_b;
            lines[4*p+3] =  hi_b |  lo_b;
        end
    end
endmodule

// File: rtl/pla_and_plane.sv
// Product plane: each column ANDs the decoder lines its mask selects.
// Assumes: an unselected line counts as 1, so an empty mask gives 1.
module pla_and_plane #(
    parameter int LW    = 12,
    parameter int N_COL = 8
) (
    input  logic [LW-1:0]       lines,
    input  logic [N_COL*LW-1:0] col_mask,
    output logic [N_COL-1:0]    terms
);
    for (genvar c = 0; c < N_COL; c++) begin : g_col
        logic [LW-1:0] sel;
        assign sel = col_mask[c*LW +: LW];
        // Column is true when every selected line is true.
        always_comb terms[c] = &(lines | ~sel);
    end
endmodule

// File: rtl/pla_or_plane.sv
// Sum plane: each output ORs the product columns its mask selects.
// Assumes: an unselected column counts as 0, so an empty mask gives 0.
module pla_or_plane #(
    parameter int N_COL = 8,
    parameter int N_OUT = 4
) (
    input  logic [N_COL-1:0]       terms,
    input  logic [N_OUT*N_COL-1:0] sum_mask,
    output logic [N_OUT-1:0]       sums
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        // Output is true when any selected column is true.
        always_comb sums[o] = |(terms & sum_mask[o*N_COL +: N_COL]);
    end
endmodule

// File: rtl/pla_cfg_store.sv
// Mask storage for both planes, loaded one mask per write.
// Assumes: addresses 0..N_COL-1 hold column masks, the next N_OUT hold sum
// masks, and any higher address is ignored. Synchronous active-low reset.
module pla_cfg_store #(
    parameter int LW    = 12,
    parameter int N_COL = 8,
    parameter int N_OUT = 4,
    parameter int AW    = 4,
    parameter int DW    = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [AW-1:0]          cfg_addr,
    input  logic [DW-1:0]          cfg_wdata,
    output logic [N_COL*LW-1:0]    col_mask,
    output logic [N_OUT*N_COL-1:0] sum_mask
);
    // Clear on reset, otherwise store the addressed mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_mask <= '0;
            sum_mask <= '0;
        end else if (cfg_we) begin
            for (int c = 0; c < N_COL; c++) begin
                if (cfg_addr == AW'(c)) col_mask[c*LW +: LW] <= cfg_wdata[LW-1:0];
            end
            for (int o = 0; o < N_OUT; o++) begin
                if (cfg_addr == AW'(N_COL + o)) sum_mask[o*N_COL +: N_COL] <= cfg_wdata[N_COL-1:0];
            end
        end
    end
endmodule

// File: rtl/dec_pla.sv
// Top of the decoded-input logic array: pair decoders, product plane,
// sum plane and mask storage. Assumes N_IN is even. REG_OUT=0 gives
// combinational outputs; REG_OUT=1 registers them (cleared by reset).
module dec_pla #(
    parameter int N_IN    = 6,
    parameter int N_COL   = 8,
    parameter int N_OUT   = 4,
    parameter bit REG_OUT = 1'b0,
    localparam int N_PAIR = N_IN / 2,
    localparam int LW     = dpla_pkg::LINES_PER_PAIR * N_PAIR,
    localparam int AW     = $clog2(N_COL + N_OUT + 1),
    localparam int DW     = dpla_pkg::max_int(LW, N_COL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IN-1:0]  pla_in,
    output logic [N_OUT-1:0] pla_out,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [DW-1:0]    cfg_wdata
);
    logic [LW-1:0]          dec_lines;
    logic [N_COL*LW-1:0]    col_mask;
    logic [N_OUT*N_COL-1:0] sum_mask;
    logic [N_COL-1:0]       col_terms;
    logic [N_OUT-1:0]       or_sums;

    pla_cfg_store #(.LW(LW), .N_COL(N_COL), .N_OUT(N_OUT), .AW(AW), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .col_mask(col_mask), .sum_mask(sum_mask)
    );

    pla_pair_dec #(.N_PAIR(N_PAIR)) u_dec (
        .in_bits(pla_in[2*N_PAIR-1:0]), .lines(dec_lines)
    );

    pla_and_plane #(.LW(LW), .N_COL(N_COL)) u_and (
        .lines(dec_lines), .col_mask(col_mask), .terms(col_terms)
    );

    pla_or_plane #(.N_COL(N_COL), .N_OUT(N_OUT)) u_or (
        .terms(col_terms), .sum_mask(sum_mask), .sums(or_sums)
    );

    if (REG_OUT) begin : g_reg_out
        logic [N_OUT-1:0] out_q;
        // Output register, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= or_sums;
        end
        assign pla_out = out_q;
    end else begin : g_comb_out
        assign pla_out = or_sums;
    end
endmodule

// File: rtl/dec_pla_chk.sv
// Property checker for dec_pla, attached through bind. Relates the pair
// inputs to the decoder lines, the masks to the columns and sums, and the
// write port to the stored masks.
module dec_pla_chk #(
    parameter int N_IN  = 6,
    parameter int N_COL = 8,
    parameter int N_OUT = 4,
    parameter int LW    = 12,
    parameter int AW    = 4,
    parameter int DW    = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_IN-1:0]        pla_in,
    input logic [LW-1:0]          dec_lines,
    input logic [N_COL*LW-1:0]    col_mask,
    input logic [N_OUT*N_COL-1:0] sum_mask,
    input logic [N_COL-1:0]       col_terms,
    input logic [N_OUT-1:0]       or_sums,
    input logic                   cfg_we,
    input logic [AW-1:0]          cfg_addr,
    input logic [DW-1:0]          cfg_wdata
);
    localparam int N_PAIR = N_IN / 2;

    for (genvar p = 0; p < N_PAIR; p++) begin : g_p
        AST_THREE_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(dec_lines[4*p +: 4]) == 3); // R2
        AST_LOW_LINE_MATCHES_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
            dec_lines[4*p +: 4] == ~(4'b1000 >> {pla_in[2*p+1], pla_in[2*p]})); // R1
    end

    for (genvar c = 0; c < N_COL; c++) begin : g_c
        AST_EMPTY_COLUMN_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
            (col_mask[c*LW +: LW] == '0) |-> col_terms[c]); // R3
        AST_FALSE_COLUMN_HAS_LOW_LINE: assert property (@(posedge clk) disable iff (!rst_n)
            !col_terms[c] |-> (|(~dec_lines & col_mask[c*LW +: LW]))); // R3
        AST_COLUMN_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr == AW'(c)) |=> col_mask[c*LW +: LW] == $past(cfg_wdata[LW-1:0])); // R6
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_o
        AST_EMPTY_SUM_FALSE: assert property (@(posedge clk) disable iff (!rst_n)
            (sum_mask[o*N_COL +: N_COL] == '0) |-> !or_sums[o]); // R5
        AST_TRUE_SUM_HAS_TERM: assert property (@(posedge clk) disable iff (!rst_n)
            or_sums[o] |-> (|(col_terms & sum_mask[o*N_COL +: N_COL]))); // R5
        AST_SUM_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr == AW'(N_COL + o)) |=> sum_mask[o*N_COL +: N_COL] == $past(cfg_wdata[N_COL-1:0])); // R6
    end

    AST_HIGH_ADDR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr >= AW'(N_COL + N_OUT)) |=> ($stable(col_mask) && $stable(sum_mask))); // R6
    AST_RESET_CLEARS_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (col_mask == '0 && sum_mask == '0)); // R7
endmodule

bind dec_pla dec_pla_chk #(
    .N_IN(N_IN), .N_COL(N_COL), .N_OUT(N_OUT), .LW(LW), .AW(AW), .DW(DW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pla_in(pla_in), .dec_lines(dec_lines),
    .col_mask(col_mask), .sum_mask(sum_mask), .col_terms(col_terms),
    .or_sums(or_sums), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
);

// File: tb/dec_pla_bench.sv
// Directed bench for dec_pla with default parameters: 6 inputs, 8 columns, 4 outputs.
module dec_pla_bench;
    localparam int N_IN  = 6;
    localparam int N_COL = 8;
    localparam int N_OUT = 4;
    localparam int LW    = 12;
    localparam int AW    = 4;
    localparam int DW    = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_IN-1:0]  pla_in = '0;
    logic [N_OUT-1:0] pla_out;
    logic             cfg_we = 1'b0;
    logic [AW-1:0]    cfg_addr = '0;
    logic [DW-1:0]    cfg_wdata = '0;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [LW-1:0]    pm [N_COL];
    logic [N_COL-1:0] sm [N_OUT];

    always #4 clk = ~clk;

    dec_pla u_dec_pla (
        .clk(clk), .rst_n(rst_n), .pla_in(pla_in), .pla_out(pla_out),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
    );

    // Reference sum of products from R1, R3 and R5.
    function automatic logic [N_OUT-1:0] ref_out(input logic [N_IN-1:0] x);
        logic [N_COL-1:0] t;
        logic [N_OUT-1:0] r;
        for (int c = 0; c < N_COL; c++) begin
            t[c] = 1'b1;
            for (int p = 0; p < N_IN/2; p++) begin
                for (int k = 0; k < 4; k++) begin
                    if (pm[c][4*p+k] && (int'({x[2*p+1], x[2*p]}) == 3 - k)) t[c] = 1'b0;
                end
            end
        end
        for (int o = 0; o < N_OUT; o++) r[o] = |(t & sm[o]);
        return r;
    endfunction

    task automatic check(input string req, input logic [N_OUT-1:0] act, input logic [N_OUT-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: in=%b out=%b expected %b", req, pla_in, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [DW-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = AW'(addr);
        cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        if (addr < N_COL) pm[addr] = data[LW-1:0];
        else if (addr < N_COL + N_OUT) sm[addr - N_COL] = data[N_COL-1:0];
    endtask

    task automatic clear_all();
        for (int a = 0; a < N_COL + N_OUT; a++) wr(a, '0);
    endtask

    task automatic sweep(input string req);
        for (int x = 0; x < (1 << N_IN); x++) begin
            pla_in = N_IN'(x);
            #1;
            check(req, pla_out, ref_out(pla_in));
        end
    endtask

    // R7: after reset every output is 0.
    task automatic t_reset();
        for (int c = 0; c < N_COL; c++) pm[c] = '0;
        for (int o = 0; o < N_OUT; o++) sm[o] = '0;
        for (int x = 0; x < (1 << N_IN); x++) begin
            pla_in = N_IN'(x);
            #1;
            check("R7", pla_out, '0);
        end
    endtask

    // R1: each single line alone, line k false only at pair value 3-k.
    task automatic t_single_line();
        for (int p = 0; p < N_IN/2; p++) begin
            for (int k = 0; k < 4; k++) begin
                clear_all();
                wr(0, DW'(1) << (4*p + k));
                wr(N_COL, DW'(1));
                for (int x = 0; x < (1 << N_IN); x++) begin
                    logic [1:0] v;
                    pla_in = N_IN'(x);
                    v = {pla_in[2*p+1], pla_in[2*p]};
                    #1;
                    check("R1", pla_out, {3'b000, (int'(v) != 3 - k)});
                end
            end
        end
    endtask

    // R4: lines 1 and 2 of a pair give the equivalence of its bits.
    task automatic t_equivalence();
        clear_all();
        for (int p = 0; p < N_IN/2; p++) begin
            wr(p, (DW'(1) << (4*p + 1)) | (DW'(1) << (4*p + 2)));
            wr(N_COL + p, DW'(1) << p);
        end
        for (int x = 0; x < (1 << N_IN); x++) begin
            logic [N_OUT-1:0] e;
            pla_in = N_IN'(x);
            e = '0;
            for (int p = 0; p < N_IN/2; p++) e[p] = ~(pla_in[2*p+1] ^ pla_in[2*p]);
            #1;
            check("R4", pla_out, e);
        end
    endtask

    // R3 and R5: empty column is 1, empty sum is 0, full column is 0.
    task automatic t_empty_masks();
        clear_all();
        wr(N_COL + 0, DW'(8'h01));
        wr(1, DW'(12'hFFF));
        wr(N_COL + 2, DW'(8'h02));
        for (int x = 0; x < (1 << N_IN); x++) begin
            pla_in = N_IN'(x);
            #1;
            check("R3", pla_out, 4'b0001);
        end
        sweep("R5");
    endtask

    // R6 and R8: write timing, high addresses ignored, no clock in the path.
    task automatic t_write_timing();
        clear_all();
        wr(N_COL, DW'(1));
        @(negedge clk);
        pla_in = 6'b000011;
        cfg_we = 1'b1;
        cfg_addr = AW'(0);
        cfg_wdata = DW'(1);
        #1;
        check("R6", pla_out, 4'b0001);
        @(posedge clk);
        #1;
        check("R6", pla_out, 4'b0000);
        @(negedge clk);
        cfg_we = 1'b0;
        pm[0] = 12'h001;
        #1;
        pla_in = 6'b000000;
        #1;
        check("R8", pla_out, 4'b0001);
        for (int a = N_COL + N_OUT; a < (1 << AW); a++) begin
            @(negedge clk);
            cfg_we = 1'b1;
            cfg_addr = AW'(a);
            cfg_wdata = '1;
            @(negedge clk);
            cfg_we = 1'b0;
        end
        sweep("R6");
    endtask

    // R9: random masks against the reference model.
    task automatic t_random();
        for (int round = 0; round < 8; round++) begin
            for (int a = 0; a < N_COL + N_OUT; a++) wr(a, DW'($urandom));
            sweep("R9");
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single_line();
        t_equivalence();
        t_empty_masks();
        t_write_timing();
        t_random();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule